// File: doc/BRIEF.md
# Two-Wire Wiper Register with Fuse-Backed Preset

This block is a two-wire serial slave that holds an 8-bit wiper position. A bus master addresses it, sends an instruction byte and then a data byte, and the new position appears on the `wiper` output. A read frame returns the current position. Two of the address bits come from strap pins, so four of these blocks can share one bus.

The instruction byte can also ask for the resulting position to be burned into a small fuse store. The store has two arrays. The first program request fills the first array and the second request fills the second. After that the store is locked. At every power-up the wiper loads from the most recently filled array, or from midscale when both arrays are blank. Fuses are modelled as sticky flip-flops. They are cleared only by `blank_n`, which stands for a virgin die. `por_n` stands for a power cycle.

The bus pins are oversampled by the system clock. Each pin passes through a two-flop synchronizer, and the block detects edges on the synchronized copies. The data line is open-drain: the block either pulls it low or lets it go.

Top module: `wiper_fuse_slave`

## Requirements
- R1: With both fuse arrays blank, the cycle after `por_n` rises shows `wiper` = 0x80, `busy` = 0, `locked` = 0 and `sda_pull` = 0.
- R2: With at least one array programmed, a power-up loads `wiper` from the second array if it is filled, or else from the first.
- R3: A falling SDA while SCL is high starts a frame, and a rising SDA while SCL is high ends it. The address byte holds `DEV_ID` in bits 7..3, `addr_pins[1:0]` in bits 2..1 and the direction in bit 0 (1 = read). Any mismatch is not acknowledged and leaves `wiper` unchanged.
- R4: A write frame is address, then instruction, then data. The slave acknowledges each byte by pulling SDA low during the 9th clock, and `wiper` takes the data byte.
- R5: When instruction bit 7 is 1, `wiper` goes to 0x80 and the data byte is ignored. Instruction bits 5..0 have no effect.
- R6: A read frame shifts out `wiper` MSB first. If the master acknowledges, the slave sends the value again. If the master does not acknowledge, the slave releases SDA.
- R7: When instruction bit 6 is 1, the resulting wiper value is written into the next blank array after `PROG_CYCLES` cycles, and `busy` is high for that whole time. `fuse_used[0]` marks the first array and `fuse_used[1]` the second, and they fill in that order.
- R8: While `busy` is high, a write address byte is not acknowledged. A read address byte is still acknowledged.
- R9: A program request made when both arrays are full leaves the arrays unchanged. It sets `locked`, which stays high until the next power-up, and `wiper` still takes the data byte.
- R10: `sda_pull` = 1 means the block pulls SDA low. It is 0 outside acknowledge and read-data slots, and in particular after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| por_n | input | 1 | Active-low power-on reset; reloads the wiper preset |
| blank_n | input | 1 | Active-low clear of the fuse store (virgin die) |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| addr_pins | input | 2 | Strapped address bits compared with address bits 2..1 |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| wiper | output | 8 | Current wiper position |
| busy | output | 1 | Fuse program operation in progress |
| locked | output | 1 | Sticky flag: program request arrived with the store full |
| fuse_used | output | 2 | Filled flags of the first (bit 0) and second (bit 1) fuse arrays |

## Verification
A slave state that drifts out of bit alignment shows up on the very next acknowledge slot, where SDA stays high when it should be low or is low when it should be high. The same happens on read data, which comes back shifted. Both appear within one byte of the fault. A wrong fuse state cannot be seen on `wiper` until the next power cycle. For that reason the bench cycles `por_n` after each program operation and compares the preset with the value it last programmed, and it checks `fuse_used` and `busy` as soon as the program window has elapsed. A busy window that is too short or too long shows up as an acknowledge where a refusal was due, or the reverse, on a write frame sent during the window.

// File: rtl/wiper_fuse_slave.sv
module wiper_fuse_slave #(
  parameter logic [4:0] DEV_ID      = 5'b01011,
  parameter int         PROG_CYCLES = 64
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       blank_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_pins,
  output logic       sda_pull,
  output logic [7:0] wiper,
  output logic       busy,
  output logic       locked,
  output logic [1:0] fuse_used
);

  localparam int         CW  = $clog2(PROG_CYCLES + 1);
  localparam logic [7:0] MID = 8'h80;

  typedef enum logic [2:0] {
    P_IDLE, P_ADDR, P_INSTR, P_DATA, P_SACK, P_READ, P_MACK, P_WAIT
  } phase_t;

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk) begin
    if (!por_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  phase_t     phase, nxt;
  logic [7:0] sh, instr;
  logic [3:0] bitcnt;
  logic       sda_low, mack_ok;

  logic addr_hit, wr_go;
  logic [7:0] new_val;
  assign addr_hit = (sh[7:1] == {DEV_ID, addr_pins});
  assign wr_go    = scl_fall && (phase == P_DATA) && (bitcnt == 4'd8);
  assign new_val  = instr[7] ? MID : sh;
  assign sda_pull = sda_low;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      phase   <= P_IDLE;
      nxt     <= P_IDLE;
      sh      <= '0;
      instr   <= '0;
      bitcnt  <= '0;
      sda_low <= 1'b0;
      mack_ok <= 1'b0;
    end else if (start_c) begin
      phase   <= P_ADDR;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (stop_c) begin
      phase   <= P_IDLE;
      sda_low <= 1'b0;
    end else if (scl_rise) begin
      case (phase)
        P_ADDR, P_INSTR, P_DATA:
          if (bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
        P_READ: bitcnt <= bitcnt + 4'd1;
        P_MACK: mack_ok <= ~sda_s;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (phase)
        P_ADDR:
          if (bitcnt == 4'd8) begin
            if (addr_hit && (sh[0] || !busy)) begin
              sda_low <= 1'b1;
              phase   <= P_SACK;
              nxt     <= sh[0] ? P_READ : P_INSTR;
            end else begin
              phase <= P_WAIT;
            end
          end
        P_INSTR:
          if (bitcnt == 4'd8) begin
            instr   <= sh;
            sda_low <= 1'b1;
            phase   <= P_SACK;
            nxt     <= P_DATA;
          end
        P_DATA:
          if (bitcnt == 4'd8) begin
            sda_low <= 1'b1;
            phase   <= P_SACK;
            nxt     <= P_WAIT;
          end
        P_SACK: begin
          bitcnt <= '0;
          if (nxt == P_READ) begin
            sh      <= wiper;
            sda_low <= ~wiper[7];
            phase   <= P_READ;
          end else begin
            sda_low <= 1'b0;
            phase   <= nxt;
          end
        end
        P_READ:
          if (bitcnt == 4'd8) begin
            sda_low <= 1'b0;
            phase   <= P_MACK;
          end else begin
            sda_low <= ~sh[6];
            sh      <= {sh[6:0], 1'b0};
          end
        P_MACK:
          if (mack_ok) begin
            sh      <= wiper;
            sda_low <= ~wiper[7];
            bitcnt  <= '0;
            phase   <= P_READ;
          end else begin
            phase <= P_WAIT;
          end
        default: ;
      endcase
    end
  end

  logic [7:0]    f0_val, f1_val, pend;
  logic          f0_set, f1_set;
  logic [CW-1:0] prog_cnt;
  logic          prog_done;
  logic [7:0]    preset;

  assign busy      = (prog_cnt != '0);
  assign prog_done = por_n && (prog_cnt == CW'(1));
  assign fuse_used = {f1_set, f0_set};
  assign preset    = f1_set ? f1_val : (f0_set ? f0_val : MID);

  always_ff @(posedge clk) begin
    if (!blank_n) begin
      f0_val <= '0;
      f1_val <= '0;
      f0_set <= 1'b0;
      f1_set <= 1'b0;
    end else if (prog_done) begin
      if (!f0_set) begin
        f0_val <= pend;
        f0_set <= 1'b1;
      end else begin
        f1_val <= pend;
        f1_set <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      wiper    <= preset;
      prog_cnt <= '0;
      pend     <= '0;
      locked   <= 1'b0;
    end else if (wr_go) begin
      wiper <= new_val;
      if (instr[6]) begin
        if (f0_set && f1_set) begin
          locked <= 1'b1;
        end else begin
          prog_cnt <= CW'(PROG_CYCLES);
          pend     <= new_val;
        end
      end
    end else if (busy) begin
      prog_cnt <= prog_cnt - CW'(1);
    end
  end

  assert_blank_mid_R1: assert property (@(posedge clk) disable iff (!por_n || !blank_n)
    ($past(!por_n) && fuse_used == 2'b00) |-> (wiper == MID));

  assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!por_n)
    (phase == P_SACK && nxt == P_INSTR) |-> !busy);

  assert_fuse_order_R7: assert property (@(posedge clk) disable iff (!blank_n)
    fuse_used != 2'b10);

  assert_fuse_quiet_R7: assert property (@(posedge clk) disable iff (!blank_n || !por_n)
    !$past(busy) |-> $stable(fuse_used));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    $past(locked) |-> locked);

  assert_lock_full_R9: assert property (@(posedge clk) disable iff (!por_n || !blank_n)
    $rose(locked) |-> (fuse_used == 2'b11));

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!por_n)
    (phase == P_IDLE) |-> !sda_pull);

endmodule

// File: tb/tb_wiper_fuse_slave.sv
module tb_wiper_fuse_slave;
  localparam int Q    = 8;
  localparam int PROG = 1500;
  localparam logic [7:0] AW   = 8'h5C;
  localparam logic [7:0] AR   = 8'h5D;
  localparam logic [7:0] APIN = 8'h5A;
  localparam logic [7:0] AID  = 8'h54;

  localparam logic [23:0] VEC [0:5] = '{
    {8'h00, 8'h3C, 8'h3C},
    {8'h00, 8'hFF, 8'hFF},
    {8'h00, 8'h00, 8'h00},
    {8'h80, 8'h55, 8'h80},
    {8'h2F, 8'hA5, 8'hA5},
    {8'h01, 8'h01, 8'h01}
  };

  logic clk = 0, por_n = 0, blank_n = 0, scl = 1, sda_m = 1;
  logic sda_pull, busy, locked;
  logic [7:0] wiper;
  logic [1:0] fuse_used;
  wire sda_line = sda_m & ~sda_pull;
  int ntot = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_fuse_slave #(.DEV_ID(5'b01011), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .por_n(por_n), .blank_n(blank_n), .scl_i(scl), .sda_i(sda_line),
    .addr_pins(2'b10), .sda_pull(sda_pull), .wiper(wiper), .busy(busy),
    .locked(locked), .fuse_used(fuse_used));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1; w(Q); scl = 1; w(Q); sda_m = 0; w(Q); scl = 0; w(Q);
  endtask

  task automatic bstop();
    sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; w(Q); scl = 1; w(Q); scl = 0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1; w(Q); scl = 1; w(Q / 2); b = sda_line; w(Q / 2); scl = 0; w(Q);
  endtask

  task automatic send(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~mack);
  endtask

  task automatic wr_frame(input logic [7:0] a, input logic [7:0] ins,
                          input logic [7:0] d, output logic [2:0] acks);
    acks = 3'b000;
    bstart();
    send(a, acks[2]);
    if (acks[2]) begin
      send(ins, acks[1]);
      send(d, acks[0]);
    end
    bstop();
  endtask

  task automatic rd_two(input logic [7:0] a, output logic ack,
                        output logic [7:0] b0, output logic [7:0] b1);
    b0 = 8'h00; b1 = 8'h00;
    bstart();
    send(a, ack);
    if (ack) begin
      recv(1'b1, b0);
      recv(1'b0, b1);
    end
    bstop();
  endtask

  task automatic power_cycle();
    por_n = 0; w(4); por_n = 1; w(2);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * PROG && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic ack;
    logic [7:0] b0, b1;
    w(5); blank_n = 1; w(3); por_n = 1; w(2);

    chk("R1 reset wiper", wiper, 8'h80);
    chk("R1 reset flags", {busy, locked, fuse_used}, 4'b0000);
    chk("R10 reset sda_pull", sda_pull, 1'b0);

    foreach (VEC[k]) begin
      wr_frame(AW, VEC[k][23:16], VEC[k][15:8], acks);
      chk("R4 write acks", acks, 3'b111);
      chk((VEC[k][23] ? "R5 midscale request" : "R4 wiper value"), wiper, VEC[k][7:0]);
      rd_two(AR, ack, b0, b1);
      chk("R6 read data", {ack, b0, b1}, {1'b1, VEC[k][7:0], VEC[k][7:0]});
      chk("R10 released after read", sda_pull, 1'b0);
    end

    wr_frame(APIN, 8'h00, 8'h11, acks);
    chk("R3 pin mismatch nack", acks, 3'b000);
    chk("R3 wiper kept", wiper, 8'h01);
    wr_frame(AID, 8'h00, 8'h22, acks);
    chk("R3 id mismatch nack", acks, 3'b000);
    chk("R3 wiper kept id", wiper, 8'h01);
    chk("R10 no drive after nack", sda_pull, 1'b0);

    wr_frame(AW, 8'h40, 8'h5A, acks);
    chk("R7 program frame acks", acks, 3'b111);
    chk("R7 busy raised", busy, 1'b1);
    chk("R7 wiper takes data", wiper, 8'h5A);
    wr_frame(AW, 8'h00, 8'h33, acks);
    chk("R8 write nack when busy", acks, 3'b000);
    rd_two(AR, ack, b0, b1);
    chk("R8 read while busy", {ack, b0}, {1'b1, 8'h5A});
    chk("R7 store still blank", fuse_used, 2'b00);
    wait_idle();
    chk("R7 first array filled", {busy, fuse_used}, 3'b001);

    wr_frame(AW, 8'h00, 8'h99, acks);
    power_cycle();
    chk("R2 preset from first array", wiper, 8'h5A);

    wr_frame(AW, 8'h40, 8'hC3, acks);
    wait_idle();
    chk("R7 second array filled", fuse_used, 2'b11);
    wr_frame(AW, 8'h00, 8'h11, acks);
    power_cycle();
    chk("R2 preset from second array", wiper, 8'hC3);

    wr_frame(AW, 8'h40, 8'h22, acks);
    chk("R9 locked request acks", acks, 3'b111);
    chk("R9 wiper still written", wiper, 8'h22);
    chk("R9 locked no busy", {locked, busy}, 2'b10);
    w(PROG + 10);
    chk("R9 store unchanged", {locked, fuse_used}, 3'b111);
    power_cycle();
    chk("R9 preset unchanged", wiper, 8'hC3);
    chk("R9 lock cleared by power-up", locked, 1'b0);

    blank_n = 0; w(2); blank_n = 1;
    power_cycle();
    chk("R1 blank store midscale", {fuse_used, wiper}, {2'b00, 8'h80});

    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule